// File: doc/BRIEF.md
# Texture Direction Detector with Candidate Selection

This block looks at a square block of luma samples and decides which way its texture runs. Rows of the block arrive one per valid cycle after a block-start strobe. The block first reduces the samples: it averages groups of horizontally neighbouring samples and drops the rows in between. It then scores eight directions, spaced 22.5 degrees apart, by how little the reduced samples change along each one. The direction with the highest score is the dominant one. One shared select derived from that index picks out the orthogonal direction, the two neighbouring directions and their scores.

From the two neighbours the block finds which side the texture leans towards. It emits a short list of four directional candidates: the dominant angle and the three nearest angle steps on the leaning side. An intra-mode search can then test only those four. When the dominant score beats the better neighbour by less than a threshold, the texture is called ambiguous and a flag asks for the full mode set instead.

Control is a three-state machine. IDLE waits for a strobe (IDLE to ACCUM on `blk_start`). ACCUM takes rows and adds scores. It restarts on a fresh strobe (ACCUM to ACCUM) and leaves when the last row is taken (ACCUM to PICK). PICK registers the results and pulses `done`. It then returns to IDLE (PICK to IDLE), or goes straight back to ACCUM if a strobe arrives in that cycle (PICK to ACCUM).

Top module: `texdir_detect`

## Requirements
- R1: Reduced sample j of a kept row is the floor of the mean of input samples SUB*j to SUB*j+SUB-1 (sample x sits at bits [x*W+W-1:x*W] of `row_in`). Only input rows whose index in the block is a multiple of SUB are kept, and the other rows have no effect on any result.
- R2: With s[r][x] the reduced block (N = FULL/SUB), the score of direction d is the sum over r = 2..N-1 and x = 2..N-3 of (2^W-1) - |s[r][x] - s[r-dy][x+dx]|. The (dx,dy) pairs for directions 0 to 7 are (1,0), (2,1), (1,1), (1,2), (0,1), (-1,2), (-1,1), (-2,1).
- R3: The dominant direction is the one with the largest score. A tie goes to the lowest direction index.
- R4: With dominant index d, the orthogonal direction is (d+4) mod 8, the lower neighbour is (d+7) mod 8 and the upper neighbour is (d+1) mod 8. Each index is output together with its own score.
- R5: `cand_list` holds four 6-bit entries, with entry k at bits [6k+5:6k]. Bits [5:3] of an entry give the dominant direction and bits [2:0] give a two's-complement step. Entry 0 has step 0. Entries 1 to 3 have step +k if the upper neighbour's score is strictly larger than the lower neighbour's, and step -k otherwise.
- R6: `full_search` is 1 exactly when the dominant score minus the larger neighbour score is less than THR (default 15).
- R7: If the last row (index FULL-1) is taken at clock edge E, `done` is high during the cycle that follows edge E+1, and only that cycle.
- R8: Between `done` pulses all result outputs hold their values. Cycles with `row_valid` low stall the block. `row_valid` while no block is open (and in the strobe cycle itself) is ignored.
- R9: A `blk_start` while a block is still open discards the partial block, and the next result depends only on the rows that follow the new strobe.
- R10: After reset, `done`, `full_search` and all index, score and list outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Opens a new block; no row is taken in this cycle |
| row_valid | input | 1 | `row_in` carries the next row of the open block |
| row_in | input | FULL*W (128) | One full-resolution row, sample x at bits [x*W+W-1:x*W] |
| done | output | 1 | One-cycle pulse when new results are on the outputs |
| dom_dir | output | 3 | Dominant direction index |
| orth_dir | output | 3 | Orthogonal direction index |
| adj_lo_dir | output | 3 | Lower neighbour direction index |
| adj_hi_dir | output | 3 | Upper neighbour direction index |
| dom_score | output | SW (13) | Score of the dominant direction |
| orth_score | output | SW (13) | Score of the orthogonal direction |
| adj_lo_score | output | SW (13) | Score of the lower neighbour |
| adj_hi_score | output | SW (13) | Score of the upper neighbour |
| cand_list | output | 24 | Four candidate entries {direction, step} |
| full_search | output | 1 | Texture ambiguous: search all modes |

## Verification
The restart path is the hardest case to reach. A strobe must land while the ACCUM state already holds a partial sum and the row history still holds rows from the abandoned block. The stimulus opens a block, feeds seven rows of a noise pattern and then strobes again with a clean pattern. The result must match a reference model that never saw the noise. Tie breaks and wrap-around are reached with hand-built patterns: a flat block gives an eight-way tie with equal neighbours, and stripe patterns put the winner at index 0 or index 7.

// File: rtl/texdir_pkg.sv
package texdir_pkg;

    localparam int NDIR   = 8;
    localparam int DIRW   = 3;
    localparam int NCAND  = 4;
    localparam int CAND_W = 2 * DIRW;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_PICK
    } tdd_state_e;

    // Horizontal step to the compared sample, per direction.
    function automatic int dir_dx(input int d);
        case (d)
            0: return 1;
            1: return 2;
            2: return 1;
            3: return 1;
            4: return 0;
            5: return -1;
            6: return -1;
            default: return -2;
        endcase
    endfunction

    // Number of kept rows back to the compared sample, per direction.
    function automatic int dir_dy(input int d);
        case (d)
            0: return 0;
            3: return 2;
            5: return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/texdir_row_hist.sv
module texdir_row_hist #(
    parameter int FULL = 16,
    parameter int SUB  = 2,
    parameter int W    = 8,
    localparam int N   = FULL / SUB,
    localparam int AW  = W + $clog2(SUB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [FULL*W-1:0] row_in,
    output logic [N*W-1:0]    cur_row,
    output logic [N*W-1:0]    prev1,
    output logic [N*W-1:0]    prev2
);

    // Horizontal reduction: floor mean of SUB adjacent samples.
    for (genvar j = 0; j < N; j++) begin : g_col
        logic [AW-1:0] sum;
        always_comb begin
            sum = '0;
            for (int k = 0; k < SUB; k++) begin
                sum = sum + AW'(row_in[(j*SUB+k)*W +: W]);
            end
        end
        assign cur_row[j*W +: W] = W'(sum / AW'(SUB));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev1 <= '0;
            prev2 <= '0;
        end else if (take) begin
            prev2 <= prev1;
            prev1 <= cur_row;
        end
    end

endmodule

// File: rtl/texdir_dir_score.sv
module texdir_dir_score #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int DX = 1,
    localparam int IW = $clog2((N - 4) * ((1 << W) - 1) + 1)
) (
    input  logic [N*W-1:0] cur_row,
    input  logic [N*W-1:0] ref_row,
    output logic [IW-1:0]  inc
);

    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] a_s;
    logic [W-1:0] b_s;
    logic [W-1:0] dif;

    always_comb begin
        inc = '0;
        a_s = '0;
        b_s = '0;
        dif = '0;
        for (int x = 2; x <= N - 3; x++) begin
            a_s = cur_row[x*W +: W];
            b_s = ref_row[(x+DX)*W +: W];
            dif = (a_s > b_s) ? (a_s - b_s) : (b_s - a_s);
            inc = inc + IW'(MAXV - dif);
        end
    end

endmodule

// File: rtl/texdir_pick.sv
module texdir_pick
    import texdir_pkg::*;
#(
    parameter int SW  = 13,
    parameter int THR = 15,
    localparam int CW = NCAND * CAND_W
) (
    input  logic [NDIR-1:0][SW-1:0] sc,
    output logic [DIRW-1:0]         best,
    output logic [DIRW-1:0]         orth,
    output logic [DIRW-1:0]         lo,
    output logic [DIRW-1:0]         hi,
    output logic [SW-1:0]           sc_best,
    output logic [SW-1:0]           sc_orth,
    output logic [SW-1:0]           sc_lo,
    output logic [SW-1:0]           sc_hi,
    output logic                    ambig,
    output logic [CW-1:0]           cands
);

    logic          lean_hi;
    logic [SW-1:0] sc_adj;
    logic [SW-1:0] gap;

    // Maximum search; strict compare keeps the lowest index on ties.
    always_comb begin
        best    = '0;
        sc_best = sc[0];
        for (int d = 1; d < NDIR; d++) begin
            if (sc[d] > sc_best) begin
                best    = DIRW'(d);
                sc_best = sc[d];
            end
        end
    end

    // One select (best) drives every neighbour index and score mux.
    assign orth    = best + DIRW'(4);
    assign lo      = best - DIRW'(1);
    assign hi      = best + DIRW'(1);
    assign sc_orth = sc[orth];
    assign sc_lo   = sc[lo];
    assign sc_hi   = sc[hi];

    assign lean_hi = sc_hi > sc_lo;
    assign sc_adj  = lean_hi ? sc_hi : sc_lo;
    assign gap     = sc_best - sc_adj;
    assign ambig   = gap < SW'(THR);

    always_comb begin
        cands = '0;
        for (int k = 0; k < NCAND; k++) begin
            if (k == 0) begin
                cands[k*CAND_W +: CAND_W] = {best, DIRW'(0)};
            end else if (lean_hi) begin
                cands[k*CAND_W +: CAND_W] = {best, DIRW'(k)};
            end else begin
                cands[k*CAND_W +: CAND_W] = {best, DIRW'(-k)};
            end
        end
    end

endmodule

// File: rtl/texdir_detect.sv
module texdir_detect
    import texdir_pkg::*;
#(
    parameter int FULL = 16,
    parameter int SUB  = 2,
    parameter int W    = 8,
    parameter int THR  = 15,
    localparam int N   = FULL / SUB,
    localparam int IW  = $clog2((N - 4) * ((1 << W) - 1) + 1),
    localparam int SW  = $clog2((N - 2) * (N - 4) * ((1 << W) - 1) + 1),
    localparam int CW  = NCAND * CAND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_start,
    input  logic              row_valid,
    input  logic [FULL*W-1:0] row_in,
    output logic              done,
    output logic [DIRW-1:0]   dom_dir,
    output logic [DIRW-1:0]   orth_dir,
    output logic [DIRW-1:0]   adj_lo_dir,
    output logic [DIRW-1:0]   adj_hi_dir,
    output logic [SW-1:0]     dom_score,
    output logic [SW-1:0]     orth_score,
    output logic [SW-1:0]     adj_lo_score,
    output logic [SW-1:0]     adj_hi_score,
    output logic [CW-1:0]     cand_list,
    output logic              full_search
);

    localparam int RW = $clog2(FULL);
    localparam int KW = $clog2(N + 1);

    tdd_state_e state;
    tdd_state_e state_nx;

    logic [RW-1:0] row_cnt;
    logic [KW-1:0] kept;
    logic          accept;
    logic          keep_row;
    logic          last_row;
    logic          score_en;

    logic [N*W-1:0] cur_row;
    logic [N*W-1:0] prev1;
    logic [N*W-1:0] prev2;

    logic [NDIR-1:0][IW-1:0] inc;
    logic [NDIR-1:0][SW-1:0] acc;

    logic [DIRW-1:0] pk_best;
    logic [DIRW-1:0] pk_orth;
    logic [DIRW-1:0] pk_lo;
    logic [DIRW-1:0] pk_hi;
    logic [SW-1:0]   pk_sc_best;
    logic [SW-1:0]   pk_sc_orth;
    logic [SW-1:0]   pk_sc_lo;
    logic [SW-1:0]   pk_sc_hi;
    logic            pk_ambig;
    logic [CW-1:0]   pk_cands;

    assign accept   = (state == ST_ACCUM) && row_valid && !blk_start;
    assign keep_row = accept && ((row_cnt % RW'(SUB)) == '0);
    assign last_row = accept && (row_cnt == RW'(FULL - 1));
    assign score_en = keep_row && (kept >= KW'(2));

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (blk_start) state_nx = ST_ACCUM;
            end
            ST_ACCUM: begin
                if (blk_start)     state_nx = ST_ACCUM;
                else if (last_row) state_nx = ST_PICK;
            end
            ST_PICK: begin
                state_nx = blk_start ? ST_ACCUM : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Row counters and score accumulators
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_cnt <= '0;
            kept    <= '0;
            acc     <= '0;
        end else if (blk_start) begin
            row_cnt <= '0;
            kept    <= '0;
            acc     <= '0;
        end else if (accept) begin
            row_cnt <= row_cnt + RW'(1);
            if (keep_row) kept <= kept + KW'(1);
            if (score_en) begin
                for (int d = 0; d < NDIR; d++) begin
                    acc[d] <= acc[d] + SW'(inc[d]);
                end
            end
        end
    end

    texdir_row_hist #(
        .FULL (FULL),
        .SUB  (SUB),
        .W    (W)
    ) i_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (keep_row),
        .row_in  (row_in),
        .cur_row (cur_row),
        .prev1   (prev1),
        .prev2   (prev2)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        localparam int DX = dir_dx(d);
        localparam int DY = dir_dy(d);
        logic [N*W-1:0] ref_row;
        if (DY == 0) begin : g_r0
            assign ref_row = cur_row;
        end else if (DY == 1) begin : g_r1
            assign ref_row = prev1;
        end else begin : g_r2
            assign ref_row = prev2;
        end
        texdir_dir_score #(
            .N  (N),
            .W  (W),
            .DX (DX)
        ) i_score (
            .cur_row (cur_row),
            .ref_row (ref_row),
            .inc     (inc[d])
        );
    end

    texdir_pick #(
        .SW  (SW),
        .THR (THR)
    ) i_pick (
        .sc      (acc),
        .best    (pk_best),
        .orth    (pk_orth),
        .lo      (pk_lo),
        .hi      (pk_hi),
        .sc_best (pk_sc_best),
        .sc_orth (pk_sc_orth),
        .sc_lo   (pk_sc_lo),
        .sc_hi   (pk_sc_hi),
        .ambig   (pk_ambig),
        .cands   (pk_cands)
    );

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done         <= 1'b0;
            dom_dir      <= '0;
            orth_dir     <= '0;
            adj_lo_dir   <= '0;
            adj_hi_dir   <= '0;
            dom_score    <= '0;
            orth_score   <= '0;
            adj_lo_score <= '0;
            adj_hi_score <= '0;
            cand_list    <= '0;
            full_search  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_PICK) begin
                done         <= 1'b1;
                dom_dir      <= pk_best;
                orth_dir     <= pk_orth;
                adj_lo_dir   <= pk_lo;
                adj_hi_dir   <= pk_hi;
                dom_score    <= pk_sc_best;
                orth_score   <= pk_sc_orth;
                adj_lo_score <= pk_sc_lo;
                adj_hi_score <= pk_sc_hi;
                cand_list    <= pk_cands;
                full_search  <= pk_ambig;
            end
        end
    end

endmodule

// File: rtl/texdir_detect_chk.sv
module texdir_detect_chk #(
    parameter int SW  = 13,
    parameter int THR = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [2:0]    dom_dir,
    input logic [2:0]    adj_lo_dir,
    input logic [2:0]    adj_hi_dir,
    input logic [SW-1:0] dom_score,
    input logic [SW-1:0] orth_score,
    input logic [SW-1:0] adj_lo_score,
    input logic [SW-1:0] adj_hi_score,
    input logic [23:0]   cand_list,
    input logic          full_search
);

    a_r3_dom_is_max: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dom_score >= orth_score) && (dom_score >= adj_lo_score) &&
                 (dom_score >= adj_hi_score));

    a_r4_adj_span: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (3'(adj_hi_dir - adj_lo_dir) == 3'd2));

    a_r5_list_head: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cand_list[5:3] == dom_dir) && (cand_list[2:0] == 3'd0));

    a_r6_clear_margin: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !full_search) |->
            (({1'b0, dom_score} - {1'b0, adj_lo_score}) >= (SW+1)'(THR)) &&
            (({1'b0, dom_score} - {1'b0, adj_hi_score}) >= (SW+1)'(THR)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(dom_dir) && $stable(dom_score) && $stable(cand_list) &&
                  $stable(full_search) && $stable(adj_lo_score));

endmodule

bind texdir_detect texdir_detect_chk #(
    .SW  (SW),
    .THR (THR)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done         (done),
    .dom_dir      (dom_dir),
    .adj_lo_dir   (adj_lo_dir),
    .adj_hi_dir   (adj_hi_dir),
    .dom_score    (dom_score),
    .orth_score   (orth_score),
    .adj_lo_score (adj_lo_score),
    .adj_hi_score (adj_hi_score),
    .cand_list    (cand_list),
    .full_search  (full_search)
);

// File: tb/test_texdir_detect.sv
module test_texdir_detect;

    localparam int FULL = 16;
    localparam int SUB  = 2;
    localparam int W    = 8;
    localparam int N    = 8;
    localparam int SW   = 13;
    localparam int THR  = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              blk_start = 1'b0;
    logic              row_valid = 1'b0;
    logic [FULL*W-1:0] row_in = '0;
    logic              done;
    logic [2:0]        dom_dir, orth_dir, adj_lo_dir, adj_hi_dir;
    logic [SW-1:0]     dom_score, orth_score, adj_lo_score, adj_hi_score;
    logic [23:0]       cand_list;
    logic              full_search;

    always #5 clk = ~clk;

    texdir_detect i_texdir_detect (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .row_valid(row_valid),
        .row_in(row_in), .done(done), .dom_dir(dom_dir), .orth_dir(orth_dir),
        .adj_lo_dir(adj_lo_dir), .adj_hi_dir(adj_hi_dir), .dom_score(dom_score),
        .orth_score(orth_score), .adj_lo_score(adj_lo_score),
        .adj_hi_score(adj_hi_score), .cand_list(cand_list), .full_search(full_search)
    );

    typedef struct {
        int d, o, l, h;
        int sd, so, sl, sh;
        int list;
        int full;
    } exp_t;

    exp_t q[$];
    exp_t last_exp;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    bit   prev_done = 0;
    int   got_sd = 0;
    int   got_list = 0;

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int pix(input int pat, input int x, input int y,
                               input int seed, input int nseed);
        int xs, ys;
        if (y % 2 == 1) return (x * 37 + y * 91 + nseed * 53 + 11) % 256;
        xs = x / 2;
        ys = y / 2;
        case (pat)
            0: return 100;
            1: return 30 * ys;
            2: return 30 * xs;
            3: return 15 * (xs + ys);
            4: return 17 * xs + 12 * ys;
            5: return 140 + 8 * (xs - 2 * ys);
            default: return ((x * 73 + y * 151 + seed * 29 + 5) * 11) % 256;
        endcase
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(input int pat, input int seed, input int nseed);
        int s [N][N];
        int sc [8];
        int dxt [8] = '{1, 2, 1, 1, 0, -1, -1, -2};
        int dyt [8] = '{0, 1, 1, 2, 1, 2, 1, 1};
        exp_t e;
        int adj, a, b, step;
        bit lean_hi;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                s[r][c] = (pix(pat, 2*c, 2*r, seed, nseed) +
                           pix(pat, 2*c+1, 2*r, seed, nseed)) / 2;
        for (int d = 0; d < 8; d++) begin
            sc[d] = 0;
            for (int r = 2; r < N; r++)
                for (int c = 2; c <= N - 3; c++) begin
                    a = s[r][c];
                    b = s[r - dyt[d]][c + dxt[d]];
                    sc[d] += 255 - ((a > b) ? a - b : b - a);
                end
        end
        e.d = 0;
        for (int d = 1; d < 8; d++) if (sc[d] > sc[e.d]) e.d = d;
        e.o = (e.d + 4) % 8;
        e.l = (e.d + 7) % 8;
        e.h = (e.d + 1) % 8;
        e.sd = sc[e.d]; e.so = sc[e.o]; e.sl = sc[e.l]; e.sh = sc[e.h];
        lean_hi = e.sh > e.sl;
        adj = lean_hi ? e.sh : e.sl;
        e.full = ((e.sd - adj) < THR) ? 1 : 0;
        e.list = 0;
        for (int k = 0; k < 4; k++) begin
            step = (k == 0) ? 0 : (lean_hi ? k : (8 - k) % 8);
            e.list |= ((e.d << 3) | step) << (6 * k);
        end
        return e;
    endfunction

    // Driver: pushes the expected result, then sends the block.
    task automatic send(input int pat, input int seed, input int nseed,
                        input bit gaps, input int nrows, input bit push);
        if (push) begin
            last_exp = model(pat, seed, nseed);
            q.push_back(last_exp);
        end
        @(negedge clk);
        blk_start = 1'b1;
        row_valid = 1'b1;   // must be ignored in the strobe cycle (R8)
        row_in    = '1;
        @(negedge clk);
        blk_start = 1'b0;
        for (int y = 0; y < nrows; y++) begin
            if (gaps && (y % 3 == 1)) begin
                row_valid = 1'b0;
                row_in    = '0;
                @(negedge clk);
            end
            for (int x = 0; x < FULL; x++) row_in[x*W +: W] = 8'(pix(pat, x, y, seed, nseed));
            row_valid = 1'b1;
            @(negedge clk);
        end
        row_valid = 1'b0;
        if (nrows == FULL) begin
            chk("R7 done not yet", done, 0);
            @(negedge clk);
            chk("R7 done latency", done, 1);
        end
    endtask

    // Monitor: pops and compares as results appear.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (prev_done) chk("R7 done width", done, 0);
            if (done) begin
                if (q.size() == 0) begin
                    chk("R7 unexpected done", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk("R3 dom_dir", dom_dir, e.d);
                    chk("R4 orth_dir", orth_dir, e.o);
                    chk("R4 adj_lo_dir", adj_lo_dir, e.l);
                    chk("R4 adj_hi_dir", adj_hi_dir, e.h);
                    chk("R2 dom_score", dom_score, e.sd);
                    chk("R2 orth_score", orth_score, e.so);
                    chk("R2 adj_lo_score", adj_lo_score, e.sl);
                    chk("R2 adj_hi_score", adj_hi_score, e.sh);
                    chk("R5 cand_list", cand_list, e.list);
                    chk("R6 full_search", full_search, e.full);
                end
            end
            prev_done = done;
        end
    end

    task automatic idle_rows(input int n);
        int sd0, list0;
        sd0 = dom_score;
        list0 = cand_list;
        for (int i = 0; i < n; i++) begin
            row_valid = 1'b1;
            for (int x = 0; x < FULL; x++) row_in[x*W +: W] = 8'((x * 19 + i * 7) % 256);
            @(negedge clk);
            chk("R8 idle no done", done, 0);
        end
        row_valid = 1'b0;
        chk("R8 hold score", dom_score, sd0);
        chk("R8 hold list", cand_list, list0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R7 watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 done", done, 0);
        chk("R10 dom_dir", dom_dir, 0);
        chk("R10 dom_score", dom_score, 0);
        chk("R10 cand_list", cand_list, 0);
        chk("R10 full_search", full_search, 0);

        send(0, 0, 1, 0, FULL, 1);   // flat: eight-way tie, ambiguous (R3, R6)
        send(1, 0, 2, 0, FULL, 1);   // row stripes: winner 0, lower neighbour wraps (R4)
        send(2, 0, 3, 1, FULL, 1);   // column stripes with stalls (R8)
        send(3, 0, 4, 0, FULL, 1);   // 45-degree texture
        send(4, 0, 5, 0, FULL, 1);   // leans to upper neighbour (R5)
        send(5, 0, 6, 0, FULL, 1);   // winner 7, upper neighbour wraps (R4)
        send(6, 1, 7, 1, FULL, 1);   // pseudo-random content

        // R1: same kept rows, different dropped rows -> same result
        send(6, 2, 8, 0, FULL, 1);
        @(negedge clk);
        got_sd = dom_score;
        got_list = cand_list;
        send(6, 2, 99, 0, FULL, 1);
        @(negedge clk);
        chk("R1 dropped rows ignored score", dom_score, got_sd);
        chk("R1 dropped rows ignored list", cand_list, got_list);

        idle_rows(5);                // R8: rows outside a block

        // R9: abandon a partial block, then a clean one
        send(6, 3, 9, 0, 7, 0);
        send(4, 0, 10, 0, FULL, 1);
        @(negedge clk);
        chk("R9 restart score", dom_score, last_exp.sd);
        chk("R9 restart list", cand_list, last_exp.list);

        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule